// File: doc/BRIEF.md
# Predicate-Aware Dispatch Conflict Resolver

This block sits at the dispatch stage of a wide in-order issue pipeline. The scheduler may place more guarded operations on one functional unit within a bundle than that unit can take. The block reads each operation's guard from a small predicate register file at dispatch time. It squashes every operation whose guard is false, so that operation frees its unit.

The surviving operations are then counted per unit. When no unit has more than one survivor, the whole bundle leaves in a single cycle. When a unit has two or more, the block spreads them over consecutive cycles, one per unit per cycle, lowest slot first. It raises a stall toward fetch and decode for as long as the bundle is still draining. A parameter selects the detection latency: 0 dispatches the first operations in the detection cycle, 1 inserts one empty bubble cycle first.

The controller has two states.
- `S_IDLE` evaluates the bundle at the inputs. It has three transitions:
  - *clean*: no conflict, so it dispatches everything and stays in `S_IDLE`.
  - *split*: conflict with latency 0, so it dispatches the first survivors and moves to `S_DRAIN`.
  - *bubble*: conflict with latency 1, so it dispatches nothing and moves to `S_DRAIN`.
- `S_DRAIN` issues the remaining captured operations. It has two transitions:
  - *more*: operations are left, so it stays in `S_DRAIN`.
  - *done*: the last operations leave, so it returns to `S_IDLE`.

Top module: `pred_dispatch_resolver`

## Requirements
- R1: After reset every predicate register reads true, no unit output is valid, every `unit_slot_o` field is 0 and `stall_o` is low.
- R2: A valid slot whose guard predicate (`slot_pred_i[s*PW +: PW]` indexes the register file) reads false is never dispatched.
- R3: A slot only ever appears on the unit named by `slot_unit_i[s*UW +: UW]`. A unit carries at most one slot per cycle, given as a 0-based slot index in `unit_slot_o[u*SW +: SW]`, and that field is 0 while the unit is not valid.
- R4: A bundle with at most one surviving operation per unit dispatches completely in its first cycle with `stall_o` low, for either latency setting.
- R5: On a unit with several survivors, they dispatch in ascending slot order in consecutive dispatch cycles. A unit with a single survivor dispatches it only in the first dispatch cycle.
- R6: With `DETECT_LAT`=1, a conflicting bundle produces one cycle with no unit valid before its first dispatch. With `DETECT_LAT`=0, the first survivors dispatch in the cycle the bundle is presented.
- R7: A conflicting bundle whose busiest unit has N survivors holds `stall_o` high for exactly `DETECT_LAT`+N-1 cycles, which are all of its cycles except the last dispatch cycle. The bundle must be held stable while `stall_o` is high, and the next bundle is taken in the cycle after `stall_o` falls.
- R8: A predicate write in the cycle a bundle is first presented is not forwarded: that bundle sees the old value. Writes during later cycles of a draining bundle do not change which of its operations dispatch.
- R9: When `pwr_en_i` is high, `pwr_val_i` is stored into predicate `pwr_idx_i` at the clock edge, and bundles presented afterwards use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_vld_i | input | NUM_SLOTS | Per-slot operation present |
| slot_unit_i | input | NUM_SLOTS*UW | Per-slot assigned unit index |
| slot_pred_i | input | NUM_SLOTS*PW | Per-slot guard predicate index |
| pwr_en_i | input | 1 | Predicate write enable |
| pwr_idx_i | input | PW | Predicate write index |
| pwr_val_i | input | 1 | Predicate write value |
| unit_vld_o | output | NUM_UNITS | Per-unit dispatch valid |
| unit_slot_o | output | NUM_UNITS*SW | Per-unit dispatched slot index |
| stall_o | output | 1 | Hold upstream stages |

## Verification
The assertions check on every cycle that each dispatched slot is valid and bound for the unit that carries it, and that no two units carry the same slot. They also check that every stalled cycle is followed by a dispatch, and that the first cycle of a conflicting bundle matches the latency setting (bubble or immediate issue). Only the bench's scenarios can show the complete issue order, the exact stall count per bundle, the squashing by false guards, and the non-forwarded write timing. These need the predicate contents and the whole bundle history, which the bench models independently for both latency settings.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_DRAIN = 1'b1
    } pdr_state_e;
endpackage

// File: rtl/pdr_pred_file.sv
module pdr_pred_file #(
    parameter int unsigned NUM_PREDS = 8,
    parameter int unsigned PW        = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PW-1:0]        wr_idx,
    input  logic                 wr_val,
    output logic [NUM_PREDS-1:0] pred_q
);
    // Reads see registered contents only: a same-cycle write is not forwarded.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_q <= '1;
        end else if (wr_en) begin
            pred_q[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/pdr_lowest_pick.sv
module pdr_lowest_pick #(
    parameter int unsigned NUM_SLOTS = 5,
    parameter int unsigned SW        = 3
) (
    input  logic [NUM_SLOTS-1:0] cand,
    output logic                 pick_vld,
    output logic [NUM_SLOTS-1:0] pick_oh,
    output logic [SW-1:0]        pick_idx,
    output logic                 multi
);
    always_comb begin
        pick_oh  = '0;
        pick_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick_oh  = '0;
                pick_oh[i] = 1'b1;
                pick_idx = SW'(i);
            end
        end
        pick_vld = |cand;
        multi    = |(cand & (cand - 1'b1));
    end
endmodule

// File: rtl/pred_dispatch_resolver.sv
module pred_dispatch_resolver #(
    parameter int unsigned NUM_SLOTS  = 5,
    parameter int unsigned NUM_UNITS  = 2,
    parameter int unsigned NUM_PREDS  = 8,
    parameter int unsigned DETECT_LAT = 0,
    localparam int unsigned SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int unsigned UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int unsigned PW = (NUM_PREDS > 1) ? $clog2(NUM_PREDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SLOTS-1:0]     slot_vld_i,
    input  logic [NUM_SLOTS*UW-1:0]  slot_unit_i,
    input  logic [NUM_SLOTS*PW-1:0]  slot_pred_i,
    input  logic                     pwr_en_i,
    input  logic [PW-1:0]            pwr_idx_i,
    input  logic                     pwr_val_i,
    output logic [NUM_UNITS-1:0]     unit_vld_o,
    output logic [NUM_UNITS*SW-1:0]  unit_slot_o,
    output logic                     stall_o
);
    import pdr_pkg::*;

    pdr_state_e             state_q, state_d;
    logic [NUM_SLOTS-1:0]   rem_q, rem_d;
    logic [NUM_PREDS-1:0]   pred_q;
    logic [NUM_SLOTS-1:0]   live_now;
    logic [NUM_SLOTS-1:0]   src_mask;
    logic [NUM_SLOTS-1:0]   sel_all;
    logic [NUM_UNITS-1:0]   pick_vld;
    logic [NUM_UNITS-1:0]   pick_multi;
    logic [NUM_SLOTS-1:0]   pick_oh  [NUM_UNITS];
    logic [SW-1:0]          pick_idx [NUM_UNITS];
    logic                   conflict;
    logic                   issue;
    logic                   in_idle;

    pdr_pred_file #(
        .NUM_PREDS (NUM_PREDS),
        .PW        (PW)
    ) u_pred_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pwr_en_i),
        .wr_idx (pwr_idx_i),
        .wr_val (pwr_val_i),
        .pred_q (pred_q)
    );

    // Guard lookup and squash of false-guarded slots.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            live_now[s] = slot_vld_i[s] & pred_q[slot_pred_i[s*PW +: PW]];
        end
    end

    assign in_idle  = (state_q == S_IDLE);
    assign src_mask = in_idle ? live_now : rem_q;

    // One lowest-slot picker per functional unit.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic [NUM_SLOTS-1:0] cand;
        always_comb begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                cand[s] = src_mask[s] && (slot_unit_i[s*UW +: UW] == UW'(u));
            end
        end
        pdr_lowest_pick #(
            .NUM_SLOTS (NUM_SLOTS),
            .SW        (SW)
        ) u_pick (
            .cand     (cand),
            .pick_vld (pick_vld[u]),
            .pick_oh  (pick_oh[u]),
            .pick_idx (pick_idx[u]),
            .multi    (pick_multi[u])
        );
    end

    always_comb begin
        sel_all = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            sel_all = sel_all | pick_oh[u];
        end
    end

    assign conflict = |pick_multi;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // Next state, stall and issue decision.
    always_comb begin
        state_d = state_q;
        rem_d   = '0;
        stall_o = 1'b0;
        issue   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (!conflict) begin
                    issue   = 1'b1;
                    state_d = S_IDLE;
                end else if (DETECT_LAT == 0) begin
                    issue   = 1'b1;
                    stall_o = 1'b1;
                    rem_d   = live_now & ~sel_all;
                    state_d = S_DRAIN;
                end else begin
                    stall_o = 1'b1;
                    rem_d   = live_now;
                    state_d = S_DRAIN;
                end
            end
            S_DRAIN: begin
                issue   = 1'b1;
                rem_d   = rem_q & ~sel_all;
                stall_o = |rem_d;
                state_d = (|rem_d) ? S_DRAIN : S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Unit outputs.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            unit_vld_o[u]            = issue & pick_vld[u];
            unit_slot_o[u*SW +: SW]  = (issue & pick_vld[u]) ? pick_idx[u] : '0;
        end
    end
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker #(
    parameter int unsigned NUM_SLOTS  = 5,
    parameter int unsigned NUM_UNITS  = 2,
    parameter int unsigned DETECT_LAT = 0,
    parameter int unsigned SW         = 3,
    parameter int unsigned UW         = 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_SLOTS-1:0]    slot_vld_i,
    input logic [NUM_SLOTS*UW-1:0] slot_unit_i,
    input logic [NUM_UNITS-1:0]    unit_vld_o,
    input logic [NUM_UNITS*SW-1:0] unit_slot_o,
    input logic                    stall_o,
    input logic                    in_idle
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        logic [SW-1:0] sidx;
        logic          sval;
        logic [UW-1:0] sunit;
        assign sidx  = unit_slot_o[u*SW +: SW];
        assign sval  = (int'(sidx) < NUM_SLOTS) ? slot_vld_i[sidx] : 1'b0;
        assign sunit = (int'(sidx) < NUM_SLOTS) ? slot_unit_i[sidx*UW +: UW] : '0;

        // R3
        assigned_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            unit_vld_o[u] |-> (sval && sunit == UW'(u)));

        for (genvar v = u + 1; v < NUM_UNITS; v++) begin : g_pair
            // R3
            distinct_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (unit_vld_o[u] && unit_vld_o[v]) |->
                (unit_slot_o[u*SW +: SW] != unit_slot_o[v*SW +: SW]));
        end
    end

    // R7
    stall_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (|unit_vld_o));

    // R6
    detect_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && stall_o) |->
        ((DETECT_LAT == 1) ? (unit_vld_o == '0) : (unit_vld_o != '0)));
endmodule

bind pred_dispatch_resolver pdr_checker #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_UNITS  (NUM_UNITS),
    .DETECT_LAT (DETECT_LAT),
    .SW         (SW),
    .UW         (UW)
) u_pdr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_vld_i  (slot_vld_i),
    .slot_unit_i (slot_unit_i),
    .unit_vld_o  (unit_vld_o),
    .unit_slot_o (unit_slot_o),
    .stall_o     (stall_o),
    .in_idle     (in_idle)
);

// File: tb/pred_dispatch_resolver_bench.sv
`timescale 1ns/100ps
module pred_dispatch_resolver_bench;
    localparam int NS = 5;
    localparam int NU = 2;
    localparam int NP = 8;
    localparam int SW = 3;
    localparam int UW = 1;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NS-1:0]    vld  [2];
    logic [NS*UW-1:0] unt  [2];
    logic [NS*PW-1:0] prd  [2];
    logic             wen  [2];
    logic [PW-1:0]    widx [2];
    logic             wval [2];
    logic [NU-1:0]    uvo  [2];
    logic [NU*SW-1:0] uso  [2];
    logic             stl  [2];

    logic mprf [2][NP];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    pred_dispatch_resolver #(.NUM_SLOTS(NS), .NUM_UNITS(NU), .NUM_PREDS(NP), .DETECT_LAT(0))
    u_pred_dispatch_resolver (
        .clk(clk), .rst_n(rst_n), .slot_vld_i(vld[0]), .slot_unit_i(unt[0]),
        .slot_pred_i(prd[0]), .pwr_en_i(wen[0]), .pwr_idx_i(widx[0]), .pwr_val_i(wval[0]),
        .unit_vld_o(uvo[0]), .unit_slot_o(uso[0]), .stall_o(stl[0]));

    pred_dispatch_resolver #(.NUM_SLOTS(NS), .NUM_UNITS(NU), .NUM_PREDS(NP), .DETECT_LAT(1))
    u_pred_dispatch_resolver_lat1 (
        .clk(clk), .rst_n(rst_n), .slot_vld_i(vld[1]), .slot_unit_i(unt[1]),
        .slot_pred_i(prd[1]), .pwr_en_i(wen[1]), .pwr_idx_i(widx[1]), .pwr_val_i(wval[1]),
        .unit_vld_o(uvo[1]), .unit_slot_o(uso[1]), .stall_o(stl[1]));

    task automatic check(input string req, input int d, input logic [NU-1:0] ev,
                         input logic [NU*SW-1:0] es, input logic estl);
        n_chk++;
        if (uvo[d] !== ev || uso[d] !== es || stl[d] !== estl) begin
            n_bad++;
            $display("FAIL %s lat%0d: vld=%b slot=%h stall=%b expected vld=%b slot=%h stall=%b",
                     req, d, uvo[d], uso[d], stl[d], ev, es, estl);
        end
    endtask

    // Present one bundle to latency-d instance, optionally with a write in its first cycle,
    // and a second write during draining (R8).
    task automatic run_bundle(input string req, input int d, input logic [NS-1:0] v,
                              input logic [NS*UW-1:0] u, input logic [NS*PW-1:0] p,
                              input logic we, input logic [PW-1:0] wi, input logic wv,
                              input logic we2, input logic [PW-1:0] wi2, input logic wv2);
        int cnt [NU];
        int lst [NU][NS];
        int nmax, total, dd;
        logic [NU-1:0]    ev;
        logic [NU*SW-1:0] es;
        logic             wrote2;
        wrote2 = 1'b0;
        for (int f = 0; f < NU; f++) cnt[f] = 0;
        for (int s = 0; s < NS; s++) begin
            if (v[s] && mprf[d][p[s*PW +: PW]]) begin
                lst[int'(u[s*UW +: UW])][cnt[int'(u[s*UW +: UW])]] = s;
                cnt[int'(u[s*UW +: UW])]++;
            end
        end
        nmax = 0;
        for (int f = 0; f < NU; f++) if (cnt[f] > nmax) nmax = cnt[f];
        total = (nmax > 1) ? d + nmax : 1;
        @(posedge clk); #1;
        vld[d] = v; unt[d] = u; prd[d] = p;
        wen[d] = we; widx[d] = wi; wval[d] = wv;
        for (int c = 0; c < total; c++) begin
            if (c > 0) begin
                @(posedge clk); #1;
                wen[d] = 1'b0;
                if (c == 1 && we2) begin
                    wen[d] = 1'b1; widx[d] = wi2; wval[d] = wv2; wrote2 = 1'b1;
                end
            end
            @(negedge clk);
            dd = (nmax > 1) ? c - d : c;
            ev = '0; es = '0;
            for (int f = 0; f < NU; f++) begin
                if (dd >= 0 && dd < cnt[f]) begin
                    ev[f] = 1'b1;
                    es[f*SW +: SW] = SW'(lst[f][dd]);
                end
            end
            check(req, d, ev, es, (c < total - 1));
        end
        if (we) mprf[d][wi] = wv;
        if (wrote2) mprf[d][wi2] = wv2;
    endtask

    task automatic idle_cycle(input int d);
        @(posedge clk); #1;
        vld[d] = '0; wen[d] = 1'b0;
        @(negedge clk);
        check("R4 idle", d, '0, '0, 1'b0);
    endtask

    task automatic set_pred(input int d, input int idx, input logic val);
        @(posedge clk); #1;
        vld[d] = '0; wen[d] = 1'b1; widx[d] = PW'(idx); wval[d] = val;
        @(posedge clk); #1;
        wen[d] = 1'b0;
        mprf[d][idx] = val;
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            vld[d] = '0; unt[d] = '0; prd[d] = '0;
            wen[d] = 1'b0; widx[d] = '0; wval[d] = 1'b0;
            for (int i = 0; i < NP; i++) mprf[d][i] = 1'b1;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int d = 0; d < 2; d++) begin
            @(negedge clk);
            check("R1 reset outputs", d, '0, '0, 1'b0);
            // R1: all predicates true after reset: one slot per unit with distinct preds.
            run_bundle("R1 preds true", d, 5'b00011, 5'b00010, {3'd0,3'd0,3'd0,3'd7,3'd2},
                       0, 0, 0, 0, 0, 0);
            // R4: no conflict -> one cycle, ascending slots on separate units
            run_bundle("R4 clean", d, 5'b10100, 5'b10000, {3'd1,3'd0,3'd3,3'd0,3'd0},
                       0, 0, 0, 0, 0, 0);
            // R9, R2: clear pred 3, then conflict removed by squash
            set_pred(d, 3, 1'b0);
            run_bundle("R2 squash", d, 5'b00111, 5'b00000, {3'd0,3'd0,3'd3,3'd0,3'd3},
                       0, 0, 0, 0, 0, 0);
            // R5, R6, R7: slots 0,1,2 on unit 0, slot 4 on unit 1, slot 3 squashed
            run_bundle("R5 R6 R7 spread", d, 5'b11111, 5'b10000, {3'd0,3'd3,3'd0,3'd0,3'd0},
                       0, 0, 0, 0, 0, 0);
            // R8: write pred 3 true in first cycle, not forwarded; pred 5 cleared while draining
            run_bundle("R8 no forward", d, 5'b11111, 5'b00000, {3'd5,3'd3,3'd0,3'd5,3'd3},
                       1, 3'd3, 1'b1, 1, 3'd5, 1'b0);
            // R9: pred 3 now true, pred 5 false
            run_bundle("R9 write seen", d, 5'b11111, 5'b00000, {3'd5,3'd3,3'd0,3'd5,3'd3},
                       0, 0, 0, 0, 0, 0);
            idle_cycle(d);
            // R3 R5 R7: random bundles
            for (int k = 0; k < 250; k++) begin
                logic [NS-1:0] rv;
                logic [NS*UW-1:0] ru;
                logic [NS*PW-1:0] rp;
                rv = NS'($urandom);
                ru = (NS*UW)'($urandom);
                rp = (NS*PW)'($urandom);
                if ($urandom_range(0, 3) == 0)
                    run_bundle("R3 R7 random", d, rv, ru, rp, 1'b1, PW'($urandom),
                               1'($urandom), 1'b0, 0, 0);
                else
                    run_bundle("R5 R8 random", d, rv, ru, rp, 1'b0, 0, 0,
                               1'($urandom), PW'($urandom), 1'($urandom));
            end
            idle_cycle(d);
        end
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule